// File: doc/BRIEF.md
# Bus Timing Parameter Legalizer

This block turns requested bus timings, given in nanoseconds, into cycle counts that a static memory bus controller can actually program. Software or a configuration sequencer supplies the bus clock frequency in units of 10 kHz together with a setup time, a strobe pulse width and a total access cycle time. A `start` pulse launches the calculation. When `done` pulses, the block presents four legal counts: setup, pulse, cycle and chip-select pulse. It also presents each count in its packed register layout, a data-float count, a warning per parameter, the number of extra passes it needed and a failure flag.

The controller accepts only sparse sets of count values. The block therefore raises any count that falls into a gap to the bottom of the next legal range. It lengthens the total cycle by every amount that setup or pulse was raised. It then requires the chip-select pulse, which spans the whole cycle, to be legal too. When the chip-select pulse has to be raised, the cycle is stretched to match and the calculation runs again.

The nanosecond to cycle conversion uses a fixed-point multiplier. That multiplier comes from an iterative divider that produces one quotient bit per clock.

Top module: `timing_legalizer`

## Requirements
- R1: A nanosecond value n converts to ((n*m + 65536) >> 16) cycles, where m = floor(freq_10k * 65536 / 100000).
- R2: Legal setup counts are 0..31 and 128..159. A setup count from 32 to 127 is raised to 128, and the amount raised is added to the cycle count.
- R3: Legal pulse counts are 0..63 and 256..319. A pulse count from 64 to 255 is raised to 256, and the amount raised is added to the cycle count.
- R4: Legal cycle counts are 0..127, 256..383, 512..639 and 768..895. A cycle count in a gap is raised to the next range minimum. A cycle count above 895 is clamped to 895 and sets `warn_cycle`.
- R5: A setup count above 159 is clamped to 159 and sets `warn_setup`. A pulse count above 319 is clamped to 319 and sets `warn_pulse`. Neither clamp adds anything to the cycle count.
- R6: The chip-select pulse starts equal to the legalized cycle. If it exceeds 319, `fail` is set, and the reported cycle and chip-select counts both equal that legalized cycle.
- R7: If the chip-select pulse falls in the pulse gap, the cycle is set to 256 and the whole pass is repeated. `recalc_cnt` counts the repeats. A repeat that would exceed MAX_RECALC (default 8) sets `fail` instead. Without failure, `cs_cnt` equals `cycle_cnt`.
- R8: Packed layouts are as follows. `setup_reg` = {setup[7], setup[4:0]}. `pulse_reg` and `cs_reg` = {value[8], value[5:0]}. `cycle_reg` = {cycle[9:8], cycle[6:0]}.
- R9: The data-float count is the conversion of 30 ns, or of 20 ns when `fast_mode` is high. It saturates at 15, and `warn_float` is set when it saturates.
- R10: `done` is high for exactly one cycle per accepted `start`. Results hold until the next `done`. A `start` while a calculation is running is ignored.
- R11: After reset, `done`, `fail`, every count and every warning are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a calculation (accepted when idle) |
| freq_10k | input | FW | Bus clock frequency in 10 kHz units |
| setup_ns | input | NSW | Requested setup time in ns |
| pulse_ns | input | NSW | Requested strobe pulse width in ns |
| cycle_ns | input | NSW | Requested total cycle time in ns |
| fast_mode | input | 1 | Selects 20 ns instead of 30 ns data-float time |
| done | output | 1 | One-cycle result-valid pulse |
| fail | output | 1 | No legal setting found |
| setup_cnt | output | CNT_W | Legal setup count |
| pulse_cnt | output | CNT_W | Legal pulse count |
| cycle_cnt | output | CNT_W | Legal cycle count |
| cs_cnt | output | CNT_W | Chip-select pulse count |
| setup_reg | output | 6 | Packed setup field |
| pulse_reg | output | 7 | Packed pulse field |
| cycle_reg | output | 9 | Packed cycle field |
| cs_reg | output | 7 | Packed chip-select pulse field |
| float_cnt | output | 4 | Data-float count |
| warn_setup | output | 1 | Setup count clamped |
| warn_pulse | output | 1 | Pulse count clamped |
| warn_cycle | output | 1 | Cycle count clamped |
| warn_float | output | 1 | Data-float count saturated |
| recalc_cnt | output | RW | Number of repeated passes |

## Verification
Some properties are checked on every cycle by the assertions. These are: the divider remainder stays below the divisor, `done` lasts one cycle, and the data-float count and the repeat count stay within their bounds. At every `done` without failure, the assertions also check that setup and pulse lie in a legal range, that the chip-select pulse equals the cycle and that it does not exceed 319. The bench scenarios must show the rest. That means the exact converted counts, the amounts raised and carried into the cycle, the clamping warnings and the failure cases. It also covers the single extra pass, the packed layouts, both data-float modes and a `start` that is ignored mid-calculation.

// File: rtl/tl_pkg.sv
package tl_pkg;
    parameter int CNT_W = 12;

    typedef struct packed {
        logic [CNT_W-1:0] val;
        logic [CNT_W-1:0] rem;
        logic             inv;
    } snap_t;

    // Sparse ranges: count ranges of 'width' values, one starting at each multiple of 2**lg_step
    function automatic snap_t snap(input logic [CNT_W-1:0] v, input int lg_step,
                                   input int width, input int count);
        snap_t r;
        int unsigned vi, idx, off, step, top;
        vi   = 32'(v);
        step = 32'(1) << lg_step;
        idx  = vi >> lg_step;
        off  = vi & (step - 1);
        top  = 32'((count - 1)) * step + 32'(width) - 1;
        r.val = v;
        r.rem = '0;
        r.inv = 1'b0;
        if (idx >= 32'(count)) begin
            r.val = CNT_W'(top);
            r.inv = 1'b1;
        end else if (off >= 32'(width)) begin
            if (idx + 1 < 32'(count)) begin
                r.val = CNT_W'((idx + 1) * step);
                r.rem = CNT_W'((idx + 1) * step - vi);
            end else begin
                r.val = CNT_W'(top);
                r.inv = 1'b1;
            end
        end
        return r;
    endfunction

    function automatic logic [5:0] pack_setup(input logic [CNT_W-1:0] v);
        return {v[7], v[4:0]};
    endfunction

    function automatic logic [6:0] pack_pulse(input logic [CNT_W-1:0] v);
        return {v[8], v[5:0]};
    endfunction

    function automatic logic [8:0] pack_cycle(input logic [CNT_W-1:0] v);
        return {v[9:8], v[6:0]};
    endfunction
endpackage

// File: rtl/tl_div.sv
module tl_div #(
    parameter int NW = 32,
    parameter int DW = 17,
    parameter int QW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [NW-1:0] dividend,
    input  logic [DW-1:0] divisor,
    output logic          done,
    output logic [QW-1:0] quotient
);
    localparam int CW = $clog2(NW);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
        logic [DW-1:0] rem;
        logic [NW-1:0] quo;
    } div_t;

    div_t q, d;
    logic [DW:0] trial;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        trial  = {q.rem, q.quo[NW-1]};
        if (!q.busy) begin
            if (start) begin
                d.busy = 1'b1;
                d.cnt  = '0;
                d.rem  = '0;
                d.quo  = dividend;
            end
        end else begin
            if (trial >= {1'b0, divisor}) begin
                d.rem = DW'(trial - {1'b0, divisor});
                d.quo = {q.quo[NW-2:0], 1'b1};
            end else begin
                d.rem = trial[DW-1:0];
                d.quo = {q.quo[NW-2:0], 1'b0};
            end
            d.cnt = q.cnt + 1'b1;
            if (q.cnt == CW'(NW - 1)) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done     = q.done;
    assign quotient = q.quo[QW-1:0];

    // R1: partial remainder never reaches the divisor
    p_rem_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |-> (q.rem < divisor));
endmodule

// File: rtl/tl_ns2cyc.sv
module tl_ns2cyc #(
    parameter int FW  = 16,
    parameter int NSW = 11
) (
    input  logic [FW-1:0]            mul,
    input  logic [NSW-1:0]           ns,
    output logic [tl_pkg::CNT_W-1:0] cyc
);
    localparam int PW = NSW + FW + 1;
    localparam int CW = tl_pkg::CNT_W;

    logic [PW-1:0] prod;
    logic [PW-1:0] sh;

    assign prod = PW'(ns) * PW'(mul) + PW'(65536);
    assign sh   = prod >> 16;

    generate
        if (PW > CW) begin : g_sat
            assign cyc = (|sh[PW-1:CW]) ? '1 : sh[CW-1:0];
        end else begin : g_ext
            assign cyc = CW'(sh);
        end
    endgenerate
endmodule

// File: rtl/tl_pass.sv
module tl_pass (
    input  logic [tl_pkg::CNT_W-1:0] setup_i,
    input  logic [tl_pkg::CNT_W-1:0] pulse_i,
    input  logic [tl_pkg::CNT_W-1:0] cycle_i,
    output logic [tl_pkg::CNT_W-1:0] setup_o,
    output logic [tl_pkg::CNT_W-1:0] pulse_o,
    output logic [tl_pkg::CNT_W-1:0] cycle_o,
    output logic [tl_pkg::CNT_W-1:0] cs_o,
    output logic                     inv_s,
    output logic                     inv_p,
    output logic                     inv_c,
    output logic                     too_long,
    output logic                     cs_raised
);
    import tl_pkg::*;

    snap_t a_s, a_p, a_c, a_cs;
    logic [CNT_W+1:0] sum;
    logic [CNT_W-1:0] sum_sat;

    always_comb begin
        a_s = snap(setup_i, 7, 32, 2);
        a_p = snap(pulse_i, 8, 64, 2);
        sum = (CNT_W+2)'(cycle_i)
            + (a_s.inv ? '0 : (CNT_W+2)'(a_s.rem))
            + (a_p.inv ? '0 : (CNT_W+2)'(a_p.rem));
        sum_sat   = (|sum[CNT_W+1:CNT_W]) ? '1 : sum[CNT_W-1:0];
        a_c       = snap(sum_sat, 8, 128, 4);
        too_long  = (a_c.val > CNT_W'(319));
        a_cs      = snap(a_c.val, 8, 64, 2);
        cs_raised = !too_long && (a_cs.rem != '0);
    end

    assign setup_o = a_s.val;
    assign pulse_o = a_p.val;
    assign cycle_o = a_c.val;
    assign cs_o    = a_cs.val;
    assign inv_s   = a_s.inv;
    assign inv_p   = a_p.inv;
    assign inv_c   = a_c.inv;
endmodule

// File: rtl/timing_legalizer.sv
module timing_legalizer #(
    parameter int FW         = 16,
    parameter int NSW        = 11,
    parameter int MAX_RECALC = 8,
    parameter int DIV_DEN    = 100000,
    localparam int RW        = $clog2(MAX_RECALC + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [FW-1:0]            freq_10k,
    input  logic [NSW-1:0]           setup_ns,
    input  logic [NSW-1:0]           pulse_ns,
    input  logic [NSW-1:0]           cycle_ns,
    input  logic                     fast_mode,
    output logic                     done,
    output logic                     fail,
    output logic [tl_pkg::CNT_W-1:0] setup_cnt,
    output logic [tl_pkg::CNT_W-1:0] pulse_cnt,
    output logic [tl_pkg::CNT_W-1:0] cycle_cnt,
    output logic [tl_pkg::CNT_W-1:0] cs_cnt,
    output logic [5:0]               setup_reg,
    output logic [6:0]               pulse_reg,
    output logic [8:0]               cycle_reg,
    output logic [6:0]               cs_reg,
    output logic [3:0]               float_cnt,
    output logic                     warn_setup,
    output logic                     warn_pulse,
    output logic                     warn_cycle,
    output logic                     warn_float,
    output logic [RW-1:0]            recalc_cnt
);
    import tl_pkg::*;

    localparam int NW = FW + 16;
    localparam int DW = $clog2(DIV_DEN + 1);

    typedef enum logic [1:0] {S_IDLE, S_DIV, S_CONV, S_LOOP} st_e;

    typedef struct packed {
        st_e              st;
        logic             fast;
        logic [NSW-1:0]   ns_s, ns_p, ns_c;
        logic [FW-1:0]    mul;
        logic [CNT_W-1:0] w_s, w_p, w_c;
        logic [3:0]       w_fl;
        logic             w_wf, w_ws, w_wp, w_wc;
        logic [RW-1:0]    w_rc;
        logic             done, fail, ws, wp, wc, wf;
        logic [CNT_W-1:0] o_s, o_p, o_c, o_cs;
        logic [3:0]       o_fl;
        logic [RW-1:0]    o_rc;
    } st_t;

    st_t q, d;

    logic             div_start, div_done;
    logic [FW-1:0]    div_quo;
    logic [NSW-1:0]   ns_vec [4];
    logic [CNT_W-1:0] cyc_vec [4];
    logic [CNT_W-1:0] p_s, p_p, p_c, p_cs;
    logic             p_is, p_ip, p_ic, p_long, p_raise;

    assign div_start = (q.st == S_IDLE) && start;

    tl_div #(.NW(NW), .DW(DW), .QW(FW)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend ({freq_10k, 16'h0000}),
        .divisor  (DW'(DIV_DEN)),
        .done     (div_done),
        .quotient (div_quo)
    );

    assign ns_vec[0] = q.ns_s;
    assign ns_vec[1] = q.ns_p;
    assign ns_vec[2] = q.ns_c;
    assign ns_vec[3] = q.fast ? NSW'(20) : NSW'(30);

    generate
        for (genvar i = 0; i < 4; i++) begin : g_conv
            tl_ns2cyc #(.FW(FW), .NSW(NSW)) u_cv (
                .mul (q.mul),
                .ns  (ns_vec[i]),
                .cyc (cyc_vec[i])
            );
        end
    endgenerate

    tl_pass u_pass (
        .setup_i   (q.w_s),
        .pulse_i   (q.w_p),
        .cycle_i   (q.w_c),
        .setup_o   (p_s),
        .pulse_o   (p_p),
        .cycle_o   (p_c),
        .cs_o      (p_cs),
        .inv_s     (p_is),
        .inv_p     (p_ip),
        .inv_c     (p_ic),
        .too_long  (p_long),
        .cs_raised (p_raise)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            S_IDLE: begin
                if (start) begin
                    d.st   = S_DIV;
                    d.fast = fast_mode;
                    d.ns_s = setup_ns;
                    d.ns_p = pulse_ns;
                    d.ns_c = cycle_ns;
                end
            end
            S_DIV: begin
                if (div_done) begin
                    d.mul = div_quo;
                    d.st  = S_CONV;
                end
            end
            S_CONV: begin
                d.w_s  = cyc_vec[0];
                d.w_p  = cyc_vec[1];
                d.w_c  = cyc_vec[2];
                d.w_wf = (cyc_vec[3] > CNT_W'(15));
                d.w_fl = d.w_wf ? 4'd15 : cyc_vec[3][3:0];
                d.w_ws = 1'b0;
                d.w_wp = 1'b0;
                d.w_wc = 1'b0;
                d.w_rc = '0;
                d.st   = S_LOOP;
            end
            S_LOOP: begin
                d.w_ws = q.w_ws | p_is;
                d.w_wp = q.w_wp | p_ip;
                d.w_wc = q.w_wc | p_ic;
                if (p_raise && (q.w_rc != RW'(MAX_RECALC))) begin
                    d.w_s  = p_s;
                    d.w_p  = p_p;
                    d.w_c  = p_cs;
                    d.w_rc = q.w_rc + 1'b1;
                end else begin
                    d.st   = S_IDLE;
                    d.done = 1'b1;
                    d.fail = p_long | p_raise;
                    d.o_s  = p_s;
                    d.o_p  = p_p;
                    d.o_c  = p_c;
                    d.o_cs = p_raise ? p_cs : p_c;
                    d.o_fl = q.w_fl;
                    d.o_rc = q.w_rc;
                    d.ws   = d.w_ws;
                    d.wp   = d.w_wp;
                    d.wc   = d.w_wc;
                    d.wf   = q.w_wf;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done       = q.done;
    assign fail       = q.fail;
    assign setup_cnt  = q.o_s;
    assign pulse_cnt  = q.o_p;
    assign cycle_cnt  = q.o_c;
    assign cs_cnt     = q.o_cs;
    assign setup_reg  = pack_setup(q.o_s);
    assign pulse_reg  = pack_pulse(q.o_p);
    assign cycle_reg  = pack_cycle(q.o_c);
    assign cs_reg     = pack_pulse(q.o_cs);
    assign float_cnt  = q.o_fl;
    assign warn_setup = q.ws;
    assign warn_pulse = q.wp;
    assign warn_cycle = q.wc;
    assign warn_float = q.wf;
    assign recalc_cnt = q.o_rc;

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_setup_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fail) |-> (setup_cnt <= CNT_W'(31) ||
                             (setup_cnt >= CNT_W'(128) && setup_cnt <= CNT_W'(159))));

    p_pulse_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fail) |-> (pulse_cnt <= CNT_W'(63) ||
                             (pulse_cnt >= CNT_W'(256) && pulse_cnt <= CNT_W'(319))));

    p_cs_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fail) |-> (cs_cnt == cycle_cnt));

    p_cs_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fail) |-> (cs_cnt <= CNT_W'(319)));

    p_recalc_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q.w_rc <= RW'(MAX_RECALC));

    p_float_max_r9: assert property (@(posedge clk) disable iff (!rst_n)
        warn_float |-> (float_cnt == 4'd15));
endmodule

// File: tb/timing_legalizer_tb.sv
`timescale 1ns/1ps
module timing_legalizer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] freq_10k = '0;
    logic [10:0] setup_ns = '0, pulse_ns = '0, cycle_ns = '0;
    logic        fast_mode = 1'b0;
    logic        done, fail;
    logic [11:0] setup_cnt, pulse_cnt, cycle_cnt, cs_cnt;
    logic [5:0]  setup_reg;
    logic [6:0]  pulse_reg, cs_reg;
    logic [8:0]  cycle_reg;
    logic [3:0]  float_cnt;
    logic        warn_setup, warn_pulse, warn_cycle, warn_float;
    logic [3:0]  recalc_cnt;

    int n_run = 0, n_fail = 0;
    int e_s, e_p, e_c, e_cs, e_fl, e_rc;
    bit e_fail, e_ws, e_wp, e_wc, e_wf;

    always #2 clk = ~clk;

    timing_legalizer u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .freq_10k(freq_10k),
        .setup_ns(setup_ns), .pulse_ns(pulse_ns), .cycle_ns(cycle_ns),
        .fast_mode(fast_mode), .done(done), .fail(fail),
        .setup_cnt(setup_cnt), .pulse_cnt(pulse_cnt), .cycle_cnt(cycle_cnt),
        .cs_cnt(cs_cnt), .setup_reg(setup_reg), .pulse_reg(pulse_reg),
        .cycle_reg(cycle_reg), .cs_reg(cs_reg), .float_cnt(float_cnt),
        .warn_setup(warn_setup), .warn_pulse(warn_pulse),
        .warn_cycle(warn_cycle), .warn_float(warn_float),
        .recalc_cnt(recalc_cnt)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int to_cyc(input int f, input int ns);
        longint m, r;
        m = (longint'(f) * 65536) / 100000;
        r = (longint'(ns) * m + 65536) >>> 16;
        return (r > 4095) ? 4095 : int'(r);
    endfunction

    // kind 0 setup, 1 pulse, 2 cycle; returns amount raised
    function automatic int msnap(inout int v, input int kind, output bit inv);
        int lo[4], hi[4], n;
        inv = 0;
        case (kind)
            0: begin lo = '{0, 128, 0, 0}; hi = '{31, 159, 0, 0}; n = 2; end
            1: begin lo = '{0, 256, 0, 0}; hi = '{63, 319, 0, 0}; n = 2; end
            default: begin lo = '{0, 256, 512, 768}; hi = '{127, 383, 639, 895}; n = 4; end
        endcase
        for (int i = 0; i < n; i++) begin
            if (v < lo[i]) begin
                int r = lo[i] - v;
                v = lo[i];
                return r;
            end else if (v <= hi[i]) begin
                return 0;
            end
        end
        v = hi[n-1];
        inv = 1;
        return 0;
    endfunction

    task automatic model(input int f, input int sn, input int pn, input int cn, input bit fm);
        int s, p, c, cs, r;
        bit iv;
        s = to_cyc(f, sn); p = to_cyc(f, pn); c = to_cyc(f, cn);
        e_rc = 0; e_fail = 0; e_ws = 0; e_wp = 0; e_wc = 0;
        forever begin
            r = msnap(s, 0, iv); if (iv) e_ws = 1; else c += r;
            r = msnap(p, 1, iv); if (iv) e_wp = 1; else c += r;
            r = msnap(c, 2, iv); if (iv) e_wc = 1;
            cs = c;
            if (cs > 319) begin e_fail = 1; break; end
            r = msnap(cs, 1, iv);
            if (r > 0) begin
                if (e_rc == 8) begin e_fail = 1; break; end
                c = cs; e_rc++;
            end else break;
        end
        e_s = s; e_p = p; e_c = c; e_cs = cs;
        e_fl = to_cyc(f, fm ? 20 : 30);
        e_wf = (e_fl > 15);
        if (e_wf) e_fl = 15;
    endtask

    task automatic launch(input int f, input int sn, input int pn, input int cn, input bit fm);
        @(negedge clk);
        freq_10k = 16'(f); setup_ns = 11'(sn); pulse_ns = 11'(pn); cycle_ns = 11'(cn);
        fast_mode = fm; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int t = 0;
        while (!done && t < 200) begin @(negedge clk); t++; end
        chk({tag, " R10 done seen"}, int'(done), 1);
    endtask

    task automatic compare(input string tag);
        chk({tag, " R1 R2 setup"}, setup_cnt, e_s);
        chk({tag, " R3 pulse"}, pulse_cnt, e_p);
        chk({tag, " R4 cycle"}, cycle_cnt, e_c);
        chk({tag, " R7 cs"}, cs_cnt, e_cs);
        chk({tag, " R6 fail"}, int'(fail), int'(e_fail));
        chk({tag, " R7 recalc"}, recalc_cnt, e_rc);
        chk({tag, " R5 warn_setup"}, int'(warn_setup), int'(e_ws));
        chk({tag, " R5 warn_pulse"}, int'(warn_pulse), int'(e_wp));
        chk({tag, " R4 warn_cycle"}, int'(warn_cycle), int'(e_wc));
        chk({tag, " R9 float"}, float_cnt, e_fl);
        chk({tag, " R9 warn_float"}, int'(warn_float), int'(e_wf));
        chk({tag, " R8 setup_reg"}, setup_reg, (e_s & 'h1f) | ((e_s & 'h80) >> 2));
        chk({tag, " R8 pulse_reg"}, pulse_reg, (e_p & 'h3f) | ((e_p & 'h100) >> 2));
        chk({tag, " R8 cycle_reg"}, cycle_reg, (e_c & 'h7f) | ((e_c & 'h300) >> 1));
        chk({tag, " R8 cs_reg"}, cs_reg, (e_cs & 'h3f) | ((e_cs & 'h100) >> 2));
    endtask

    task automatic run(input string tag, input int f, input int sn, input int pn,
                       input int cn, input bit fm);
        model(f, sn, pn, cn, fm);
        launch(f, sn, pn, cn, fm);
        wait_done(tag);
        compare(tag);
        @(negedge clk);
        chk({tag, " R10 done one cycle"}, int'(done), 0);
        chk({tag, " R10 hold cycle"}, cycle_cnt, e_c);
    endtask

    task automatic t_reset();
        chk("reset R11 done", int'(done), 0);
        chk("reset R11 fail", int'(fail), 0);
        chk("reset R11 cycle", cycle_cnt, 0);
        chk("reset R11 setup", setup_cnt, 0);
        chk("reset R11 warns", int'({warn_setup, warn_pulse, warn_cycle, warn_float}), 0);
    endtask

    task automatic t_nominal();    run("nominal", 10000, 70, 290, 600, 1'b0); endtask
    task automatic t_gap_fail();   run("gapfail", 50000, 100, 150, 200, 1'b0); endtask
    task automatic t_recalc();     run("recalc", 10000, 70, 290, 1000, 1'b0); endtask
    task automatic t_clamp();      run("clamp", 65535, 2047, 10, 100, 1'b0); endtask
    task automatic t_cycle_clamp(); run("cycclamp", 65535, 5, 10, 1400, 1'b0); endtask
    task automatic t_fast();       run("fast", 10000, 30, 80, 120, 1'b1); endtask
    task automatic t_zero();       run("zerofreq", 0, 500, 500, 500, 1'b0); endtask
    task automatic t_gap_ok();     run("gapok", 20000, 200, 400, 300, 1'b0); endtask

    task automatic t_busy_ignore();
        bit again = 0;
        model(10000, 70, 290, 600, 1'b0);
        launch(10000, 70, 290, 600, 1'b0);
        repeat (3) @(negedge clk);
        freq_10k = 16'd50000; setup_ns = 11'd100; cycle_ns = 11'd200; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done("busy");
        compare("busy R10 ignored start");
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (done) again = 1;
        end
        chk("busy R10 no second done", int'(again), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_nominal();
        t_gap_fail();
        t_recalc();
        t_clamp();
        t_cycle_clamp();
        t_fast();
        t_zero();
        t_gap_ok();
        t_busy_ignore();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule